// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches recent virtual-to-physical page translations so that most memory accesses skip the page-table read in main memory. Any slot can hold any translation, so the cache is fully associative. Each stored translation is keyed on the virtual page number together with an address-space number that names the owning process. Translations for several processes can therefore live side by side, and a context switch needs no flush. A lookup answers in the same cycle, from the state held before the next clock edge. The answer is hit or miss, the physical address, and a fault flag for a write to a page that does not allow writes.

When a lookup misses, the page-table walker outside the block fetches the translation and installs it through the refill port. The refill goes into a free slot if one exists. Otherwise it replaces the slot that was used least recently. Software-directed invalidation is also supported: one input drops every translation of one address space, and another drops every translation.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is empty, and every lookup misses.
- R2: A lookup with `lk_valid` high hits when a valid slot holds both its page number (`lk_vaddr[31:12]`) and its address-space number. Otherwise it raises `lk_miss`. With `lk_valid` low, both flags stay low. At most one slot ever matches.
- R3: On a hit, `lk_paddr` is the stored 20-bit physical page number in bits 31:12, followed by `lk_vaddr[11:0]` unchanged. When there is no hit, `lk_paddr` is zero.
- R4: The same page number under two different address-space numbers occupies two separate slots, and each slot returns its own physical page.
- R5: `lk_wprot_fault` is high exactly when a lookup hits, `lk_write` is high, and the matching slot was installed with `fill_writable` low. `lk_hit` stays high in that case.
- R6: A refill takes effect at the clock edge. A lookup in the same cycle sees the contents from before that edge.
- R7: While any slot is empty, a refill that is not a duplicate fills an empty slot, and no valid translation is lost.
- R8: When all slots are valid, a new refill replaces the least recently used translation. A hitting lookup and a refill each count as a use. When both happen in one cycle, the refilled slot counts as the more recent.
- R9: A refill whose page number and address-space number match a valid slot overwrites that slot's physical page and write permission, and creates no second copy.
- R10: `flush_asn_valid` invalidates every slot holding `flush_asn`, and leaves the slots of other address spaces intact.
- R11: `flush_all` invalidates every slot.
- R12: When a flush and a refill fall in the same cycle, the flush applies to the old contents first. The refilled slot ends up valid with the new translation, whatever the flush selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_asn | input | 8 | Address-space number of the lookup |
| lk_vaddr | input | 32 | Virtual address (page number 31:12, offset 11:0) |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Requested and not found |
| lk_wprot_fault | output | 1 | Write to a page without write permission |
| lk_paddr | output | 32 | Physical address on hit, zero otherwise |
| fill_valid | input | 1 | Install a translation at the next edge |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_asn | input | 8 | Address-space number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_writable | input | 1 | Write permission of the installed page |
| flush_asn_valid | input | 1 | Invalidate all slots of `flush_asn` |
| flush_asn | input | 8 | Address space to invalidate |
| flush_all | input | 1 | Invalidate every slot |

## Verification
Two pairs of functions can coincide in one cycle.

A lookup can arrive together with a refill. The bench provokes this by looking up the very page being installed, and by hitting one slot while a full cache evicts another. The lookup must show the state from before the edge, and the refill must end up most recent in the replacement order.

A flush can arrive together with a refill, including a refill whose duplicate slot the flush selects. The refilled translation must survive, and the other selected slots must disappear.

A behavioural model with a recency queue follows every cycle of a long mixed run and judges all four outputs.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;
    localparam int ASN_W = 8;
    localparam int OFF_W = 12;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [ASN_W-1:0] asn;
        logic [PPN_W-1:0] ppn;
        logic             writable;
    } tlb_line_t;

    function automatic logic tag_eq(tlb_line_t l, logic [VPN_W-1:0] vpn, logic [ASN_W-1:0] asn);
        return (l.vpn == vpn) && (l.asn == asn);
    endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store import tlb_pkg::*; #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  tlb_line_t             wr_line,
    input  logic                  flush_asn_v,
    input  logic [ASN_W-1:0]      flush_asn,
    input  logic                  flush_all,
    output logic [ENTRIES-1:0]    valid_o,
    output tlb_line_t [ENTRIES-1:0] lines_o
);
    logic [ENTRIES-1:0]      valid_q;
    tlb_line_t [ENTRIES-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all || (flush_asn_v && line_q[i].asn == flush_asn))
                    valid_q[i] <= 1'b0;
            end
            if (wr_en) begin
                valid_q[wr_idx] <= 1'b1;
                line_q[wr_idx]  <= wr_line;
            end
        end
    end

    assign valid_o = valid_q;
    assign lines_o = line_q;

    assert_reset_empty_R1: assert property (@(posedge clk) rst |=> valid_q == '0);
    assert_flush_all_R11: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !wr_en) |=> valid_q == '0);
    assert_fill_survives_R12: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(wr_idx)]);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flush_chk
        assert_flush_asn_R10: assert property (@(posedge clk) disable iff (rst)
            (flush_asn_v && !wr_en && valid_q[g] && line_q[g].asn == flush_asn) |=> !valid_q[g]);
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]      valid,
    input  tlb_line_t [ENTRIES-1:0] lines,
    input  logic [VPN_W-1:0]        vpn,
    input  logic [ASN_W-1:0]        asn,
    output logic [ENTRIES-1:0]      match_vec,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid[g] && tag_eq(lines[g], vpn, asn);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match_vec[i]) idx = IDX_W'(i);
    end
    assign any = |match_vec;
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               use_a,
    input  logic [IDX_W-1:0]   use_a_idx,
    input  logic               use_b,
    input  logic [IDX_W-1:0]   use_b_idx,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   victim
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] age_a [ENTRIES];
    logic [IDX_W-1:0] age_b [ENTRIES];
    logic [ENTRIES-1:0] oldest_vec;

    always_comb begin
        age_a = age_q;
        if (use_a) begin
            for (int i = 0; i < ENTRIES; i++)
                if (age_q[i] < age_q[use_a_idx]) age_a[i] = age_q[i] + 1'b1;
            age_a[use_a_idx] = '0;
        end
        age_b = age_a;
        if (use_b) begin
            for (int i = 0; i < ENTRIES; i++)
                if (age_a[i] < age_a[use_b_idx]) age_b[i] = age_a[i] + 1'b1;
            age_b[use_b_idx] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else begin
            age_q <= age_b;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = (age_q[g] == OLDEST);
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (oldest_vec[i]) victim = IDX_W'(i);
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (!valid[i]) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
    end

    assert_single_oldest_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot(oldest_vec));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate import tlb_pkg::*; #(
    parameter int ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [ASN_W-1:0] lk_asn,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_wprot_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [ASN_W-1:0] fill_asn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_writable,
    input  logic             flush_asn_valid,
    input  logic [ASN_W-1:0] flush_asn,
    input  logic             flush_all
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]      valid;
    tlb_line_t [ENTRIES-1:0] lines;
    logic [ENTRIES-1:0]      lk_match, fill_match;
    logic                    lk_any, fill_dup;
    logic [IDX_W-1:0]        lk_idx, dup_idx, victim, fill_idx;
    tlb_line_t               hit_line, new_line;

    assign new_line = '{vpn: fill_vpn, asn: fill_asn, ppn: fill_ppn, writable: fill_writable};
    assign fill_idx = fill_dup ? dup_idx : victim;

    tlb_store #(.ENTRIES(ENTRIES)) i_store (
        .clk(clk), .rst(rst),
        .wr_en(fill_valid), .wr_idx(fill_idx), .wr_line(new_line),
        .flush_asn_v(flush_asn_valid), .flush_asn(flush_asn), .flush_all(flush_all),
        .valid_o(valid), .lines_o(lines)
    );

    tlb_match #(.ENTRIES(ENTRIES)) i_lk_match (
        .valid(valid), .lines(lines),
        .vpn(lk_vaddr[VA_W-1:OFF_W]), .asn(lk_asn),
        .match_vec(lk_match), .any(lk_any), .idx(lk_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES)) i_fill_match (
        .valid(valid), .lines(lines),
        .vpn(fill_vpn), .asn(fill_asn),
        .match_vec(fill_match), .any(fill_dup), .idx(dup_idx)
    );

    tlb_lru #(.ENTRIES(ENTRIES)) i_lru (
        .clk(clk), .rst(rst),
        .use_a(lk_hit), .use_a_idx(lk_idx),
        .use_b(fill_valid), .use_b_idx(fill_idx),
        .valid(valid), .victim(victim)
    );

    assign hit_line       = lines[lk_idx];
    assign lk_hit         = lk_valid && lk_any;
    assign lk_miss        = lk_valid && !lk_any;
    assign lk_wprot_fault = lk_hit && lk_write && !hit_line.writable;
    assign lk_paddr       = lk_hit ? {hit_line.ppn, lk_vaddr[OFF_W-1:0]} : '0;

    assert_unique_match_R2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> $onehot(lk_match));
    assert_fill_free_slot_R7: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_dup && !(&valid) && !flush_all && !flush_asn_valid)
        |=> $countones(valid) == $past($countones(valid)) + 1);
    assert_dup_no_growth_R9: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_dup && !flush_all && !flush_asn_valid)
        |=> $countones(valid) == $past($countones(valid)));
endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, lk_write = 0;
    logic [7:0]  lk_asn = 0;
    logic [31:0] lk_vaddr = 0;
    logic        lk_hit, lk_miss, lk_wprot_fault;
    logic [31:0] lk_paddr;
    logic        fill_valid = 0, fill_writable = 0;
    logic [19:0] fill_vpn = 0, fill_ppn = 0;
    logic [7:0]  fill_asn = 0;
    logic        flush_asn_valid = 0, flush_all = 0;
    logic [7:0]  flush_asn = 0;

    always #5ns clk = ~clk;

    tlb_xlate i_tlb_xlate (.*);

    localparam int N = 32;
    bit          m_v   [N];
    logic [19:0] m_vpn [N];
    logic [7:0]  m_asn [N];
    logic [19:0] m_ppn [N];
    bit          m_wr  [N];
    int          rec[$];
    int          n_chk = 0, n_fail = 0;
    string       tag = "R1";
    bit          done = 0;

    function automatic int m_find(logic [19:0] vpn, logic [7:0] asn);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_asn[i] == asn) return i;
        return -1;
    endfunction

    function automatic void m_touch(int k);
        foreach (rec[j]) if (rec[j] == k) begin rec.delete(j); break; end
        rec.push_front(k);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int h;
        bit eh;
        logic [31:0] ep;
        h  = m_find(lk_vaddr[31:12], lk_asn);
        eh = lk_valid && h >= 0;
        ep = eh ? {m_ppn[h], lk_vaddr[11:0]} : 32'h0;
        chk(lk_hit == eh, tag, "hit", 32'(lk_hit), 32'(eh));
        chk(lk_miss == (lk_valid && !eh), tag, "miss", 32'(lk_miss), 32'(lk_valid && !eh));
        chk(lk_paddr == ep, tag, "paddr", lk_paddr, ep);
        chk(lk_wprot_fault == (eh && lk_write && !m_wr[h]), tag, "fault",
            32'(lk_wprot_fault), 32'(eh && lk_write && !m_wr[h]));
    endtask

    task automatic update();
        int h, d, vic;
        h = lk_valid ? m_find(lk_vaddr[31:12], lk_asn) : -1;
        d = fill_valid ? m_find(fill_vpn, fill_asn) : -1;
        vic = rec[$];
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
        if (d >= 0) vic = d;
        if (h >= 0) m_touch(h);
        for (int i = 0; i < N; i++)
            if (flush_all || (flush_asn_valid && m_asn[i] == flush_asn)) m_v[i] = 0;
        if (fill_valid) begin
            m_v[vic] = 1; m_vpn[vic] = fill_vpn; m_asn[vic] = fill_asn;
            m_ppn[vic] = fill_ppn; m_wr[vic] = fill_writable;
            m_touch(vic);
        end
    endtask

    task automatic idle();
        lk_valid = 0; lk_write = 0; fill_valid = 0; flush_asn_valid = 0; flush_all = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
        @(posedge clk);
        update();
        #1ns;
        idle();
    endtask

    task automatic look(logic [19:0] vpn, logic [7:0] asn, bit wr);
        lk_valid = 1; lk_write = wr; lk_asn = asn;
        lk_vaddr = {vpn, 12'($urandom_range(0, 4095))};
    endtask

    task automatic fill(logic [19:0] vpn, logic [7:0] asn, logic [19:0] ppn, bit wr);
        fill_valid = 1; fill_vpn = vpn; fill_asn = asn; fill_ppn = ppn; fill_writable = wr;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin rec.push_back(i); m_v[i] = 0; m_wr[i] = 0; end
        repeat (3) @(posedge clk);
        #1ns rst = 0;
        // R1: empty after reset
        tag = "R1";
        for (int i = 0; i < 4; i++) begin look(20'(i * 7), 8'(i), 0); cyc(); end
        chk(lk_hit == 0, "R1", "idle hit", 32'(lk_hit), 0);
        // R2/R3: install and hit
        tag = "R2";
        fill(20'h00010, 8'd1, 20'hA0010, 1); cyc();
        fill(20'h00011, 8'd1, 20'hA0011, 1); cyc();
        look(20'h00010, 8'd1, 0); cyc();
        look(20'h00010, 8'd2, 0); cyc();
        tag = "R3";
        look(20'h00011, 8'd1, 0); lk_vaddr[11:0] = 12'hFFF; cyc();
        look(20'h00011, 8'd1, 0); lk_vaddr[11:0] = 12'h000; cyc();
        // R4: same page, two address spaces
        tag = "R4";
        fill(20'h00010, 8'd2, 20'hB0010, 0); cyc();
        look(20'h00010, 8'd1, 0); cyc();
        look(20'h00010, 8'd2, 0); cyc();
        // R5: write protection
        tag = "R5";
        look(20'h00010, 8'd2, 1); cyc();
        look(20'h00010, 8'd1, 1); cyc();
        look(20'h00077, 8'd2, 1); cyc();
        // R6: lookup of the page being installed, same cycle
        tag = "R6";
        fill(20'h00030, 8'd3, 20'hC0030, 1); look(20'h00030, 8'd3, 0); cyc();
        look(20'h00030, 8'd3, 0); cyc();
        // R7: fill up all slots, nothing lost
        tag = "R7";
        for (int i = 0; i < 28; i++) begin fill(20'h100 + 20'(i), 8'd5, 20'h5000 + 20'(i), 1); cyc(); end
        for (int i = 0; i < 28; i++) begin look(20'h100 + 20'(i), 8'd5, 0); cyc(); end
        look(20'h00010, 8'd1, 0); cyc();
        // R8: eviction order, hit plus refill same cycle
        tag = "R8";
        fill(20'h200, 8'd6, 20'h6000, 1); look(20'h00011, 8'd1, 0); cyc();
        look(20'h00010, 8'd2, 0); cyc();
        fill(20'h201, 8'd6, 20'h6001, 1); cyc();
        for (int i = 0; i < 6; i++) begin look(20'h100 + 20'(i), 8'd5, 0); cyc(); end
        look(20'h00011, 8'd1, 0); cyc();
        // R9: duplicate refill
        tag = "R9";
        fill(20'h105, 8'd5, 20'h7777, 0); cyc();
        look(20'h105, 8'd5, 1); cyc();
        for (int i = 0; i < 28; i++) begin look(20'h100 + 20'(i), 8'd5, 0); cyc(); end
        // R10: flush one address space
        tag = "R10";
        flush_asn_valid = 1; flush_asn = 8'd5; cyc();
        look(20'h103, 8'd5, 0); cyc();
        look(20'h200, 8'd6, 0); cyc();
        // R12: flush and refill together, refill on a selected duplicate
        tag = "R12";
        fill(20'h200, 8'd6, 20'h6100, 1); flush_asn_valid = 1; flush_asn = 8'd6; cyc();
        look(20'h200, 8'd6, 0); cyc();
        look(20'h201, 8'd6, 0); cyc();
        fill(20'h300, 8'd7, 20'h7300, 1); flush_all = 1; cyc();
        look(20'h300, 8'd7, 0); cyc();
        // R11: global flush
        tag = "R11";
        flush_all = 1; cyc();
        look(20'h300, 8'd7, 0); cyc();
        look(20'h00010, 8'd1, 0); cyc();
        // R8: long mixed run against the recency model
        tag = "R8";
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 2) != 0)
                look(20'($urandom_range(0, 39)), 8'($urandom_range(0, 2)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 2) == 0)
                fill(20'($urandom_range(0, 39)), 8'($urandom_range(0, 2)),
                     20'($urandom), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 99) == 0) begin
                flush_asn_valid = 1; flush_asn = 8'($urandom_range(0, 2));
            end
            if ($urandom_range(0, 499) == 0) flush_all = 1;
            cyc();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule